// File: doc/BRIEF.md
# Misplaced-Line Re-Access Unit

A resizable cache can run in split modes where part of its array acts as a pseudo lower level. Lines swapped in such a mode can end up at a set other than their home set. This can still be true after the cache returns to full-size operation. This unit tracks those lines so that full-size accesses can still find them without a bulk writeback.

For every home set and every pseudo level, the unit keeps a bitmap with one bit per way. A set bit means that the way at the level's alternate index holds a line whose home is this set. The alternate index for pseudo level 0 is the home index with its most significant bit inverted. For pseudo level 1 the next lower bit is inverted instead.

When a normal lookup misses, the unit reads the home set's maps in level order. It issues an extra lookup at the alternate index that enables only the flagged ways. On a hit it orders the line to be swapped back home and updates the flag. When no flag remains to be tried, it hands the miss to next-level memory. During split mode, the swap logic writes the maps through a dedicated mark port.

Top module: `mlr_reaccess`

## Requirements
- R1: After reset, all bitmaps are zero, `req_ready` is 1, and `probe_valid`, `swap_valid` and `fwd_valid` are 0.
- R2: A cycle with `mark_valid` high writes `mark_set` into the bit for way `mark_way` in the map of level `mark_level` for home set `mark_idx`. A value of 1 flags a misplaced line and 0 clears the flag. The effect is visible in the way enables of later extra lookups.
- R3: A request with `req_miss` low is a normal hit and is ignored. No probe or forward follows, and `req_ready` stays 1.
- R4: A miss accepted in idle, for which some level has a nonzero map, raises `probe_valid` in the next cycle. In that probe, `probe_way_en` equals that level's map and `probe_idx` equals the home index with bit (IDX_W-1-level) inverted.
- R5: During a probe, `probe_cnt` equals the number of ones in `probe_way_en`, and `probe_level` names the level being probed.
- R6: Levels are tried in ascending order, and levels with an empty map are skipped. A probe miss with a nonzero later map moves to that later level in the next cycle.
- R7: When no remaining level has a flagged way, `fwd_valid` pulses for exactly one cycle with `fwd_idx` set to the home index. No probe is made. This happens in the cycle after acceptance, or in the cycle after the last probe miss.
- R8: A probe hit (`rsp_valid` and `rsp_hit`) gives a one-cycle `swap_valid` in the next cycle. The swap carries the home index, the alternate index, the hit way and the level. The hit way's flag becomes `rsp_victim_misplaced`: it is cleared when the line sent away is correctly placed and kept when that line is itself misplaced.
- R9: While a probe waits for its response, `probe_valid`, `probe_idx` and `probe_way_en` hold steady. During that time `req_ready` is 0 and new requests are ignored.
- R10: If a mark and a swap update address the same bit in the same cycle, the swap update wins. A mark to a different bit in that cycle is still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Normal lookup result presented |
| req_miss | input | 1 | 1 when the normal lookup missed |
| req_idx | input | IDX_W | Home set index of the access |
| req_ready | output | 1 | Unit idle and accepting requests |
| mark_valid | input | 1 | Write one map bit |
| mark_level | input | LVL_W | Pseudo level of the map |
| mark_idx | input | IDX_W | Home set of the map |
| mark_way | input | WAY_W | Way bit to write |
| mark_set | input | 1 | Value written (1 flag, 0 clear) |
| probe_valid | output | 1 | Extra lookup in progress |
| probe_idx | output | IDX_W | Alternate index to read |
| probe_way_en | output | WAYS | Ways enabled for the extra lookup |
| probe_cnt | output | CNT_W | Number of enabled ways |
| probe_level | output | LVL_W | Level being probed |
| rsp_valid | input | 1 | Extra lookup result presented |
| rsp_hit | input | 1 | Extra lookup found the line |
| rsp_way | input | WAY_W | Way that hit |
| rsp_victim_misplaced | input | 1 | Line sent to the alternate set is itself misplaced |
| swap_valid | output | 1 | Swap order, one cycle |
| swap_home_idx | output | IDX_W | Set that receives the found line |
| swap_alt_idx | output | IDX_W | Set the line is taken from |
| swap_way | output | WAY_W | Way at the alternate index |
| swap_level | output | LVL_W | Level of the swap |
| fwd_valid | output | 1 | Miss passed to next-level memory, one cycle |
| fwd_idx | output | IDX_W | Home index of the forwarded miss |

## Verification
Each result is due at a fixed distance from its trigger. A probe or a forward appears in the first cycle after the edge that accepts a miss. The next probe or forward follows one cycle after the edge that takes a miss response. A swap follows one cycle after the edge that takes a hit. A map write shows up in the first extra lookup made after the edge that takes it. The bench drives and samples on the falling edge. It waits exactly one clock per step and compares against a bench-side copy of the maps, so a result that arrives a cycle early or late fails the check. Stall cycles are inserted during probes to test that the probe holds steady and that requests made while busy are dropped.

// File: rtl/mlr_pkg.sv
package mlr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_SWAP  = 2'd2,
        ST_FWD   = 2'd3
    } seq_st_e;

    function automatic int unsigned ones_of(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int b = 0; b < 64; b++) begin
            n += int'(v[b]);
        end
        return n;
    endfunction

endpackage

// File: rtl/mlr_map_store.sv
module mlr_map_store #(
    parameter int IDX_W  = 4,
    parameter int WAYS   = 4,
    parameter int LEVELS = 2,
    parameter int LVL_W  = 1,
    parameter int WAY_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mk_we,
    input  logic [LVL_W-1:0]              mk_lvl,
    input  logic [IDX_W-1:0]              mk_idx,
    input  logic [WAY_W-1:0]              mk_way,
    input  logic                          mk_val,
    input  logic                          up_we,
    input  logic [LVL_W-1:0]              up_lvl,
    input  logic [IDX_W-1:0]              up_idx,
    input  logic [WAY_W-1:0]              up_way,
    input  logic                          up_val,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [LEVELS-1:0][WAYS-1:0]   rd_maps
);
    localparam int SETS = 1 << IDX_W;

    logic [WAYS-1:0] map_q [LEVELS][SETS];

    // The swap update is written last so it overrides a mark to the same bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < LEVELS; l++) begin
                for (int s = 0; s < SETS; s++) begin
                    map_q[l][s] <= '0;
                end
            end
        end else begin
            if (mk_we) begin
                map_q[mk_lvl][mk_idx][mk_way] <= mk_val;
            end
            if (up_we) begin
                map_q[up_lvl][up_idx][up_way] <= up_val;
            end
        end
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_rd
        assign rd_maps[g] = map_q[g][rd_idx];
    end

endmodule

// File: rtl/mlr_level_pick.sv
module mlr_level_pick #(
    parameter int WAYS   = 4,
    parameter int LEVELS = 2,
    parameter int LVL_W  = 1
) (
    input  logic [LEVELS-1:0][WAYS-1:0] maps,
    input  logic [LVL_W:0]              from_lvl,
    output logic                        found,
    output logic [LVL_W-1:0]            lvl
);
    // Scan downward so the lowest qualifying level is the one that remains.
    always_comb begin
        found = 1'b0;
        lvl   = '0;
        for (int l = LEVELS - 1; l >= 0; l--) begin
            if (l >= int'(from_lvl) && |maps[l]) begin
                found = 1'b1;
                lvl   = LVL_W'(l);
            end
        end
    end

endmodule

// File: rtl/mlr_seq.sv
module mlr_seq
    import mlr_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int WAYS   = 4,
    parameter int LEVELS = 2,
    parameter int LVL_W  = 1,
    parameter int WAY_W  = 2,
    parameter int CNT_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_miss,
    input  logic [IDX_W-1:0]            req_idx,
    output logic                        req_ready,
    input  logic                        rsp_valid,
    input  logic                        rsp_hit,
    input  logic [WAY_W-1:0]            rsp_way,
    input  logic                        rsp_victim_misplaced,
    input  logic [LEVELS-1:0][WAYS-1:0] maps,
    input  logic                        pick_found,
    input  logic [LVL_W-1:0]            pick_lvl,
    output logic [IDX_W-1:0]            rd_idx,
    output logic [LVL_W:0]              pick_from,
    output logic                        up_we,
    output logic [LVL_W-1:0]            up_lvl,
    output logic [IDX_W-1:0]            up_idx,
    output logic [WAY_W-1:0]            up_way,
    output logic                        up_val,
    output logic                        probe_valid,
    output logic [IDX_W-1:0]            probe_idx,
    output logic [WAYS-1:0]             probe_way_en,
    output logic [CNT_W-1:0]            probe_cnt,
    output logic [LVL_W-1:0]            probe_level,
    output logic                        swap_valid,
    output logic [IDX_W-1:0]            swap_home_idx,
    output logic [IDX_W-1:0]            swap_alt_idx,
    output logic [WAY_W-1:0]            swap_way,
    output logic [LVL_W-1:0]            swap_level,
    output logic                        fwd_valid,
    output logic [IDX_W-1:0]            fwd_idx
);
    typedef struct packed {
        logic [IDX_W-1:0] home;
        logic [LVL_W-1:0] lvl;
        logic [WAYS-1:0]  en;
        logic [WAY_W-1:0] way;
    } ctx_t;

    seq_st_e st_q;
    ctx_t    ctx_q;
    logic    accept;
    logic    rsp_take;

    function automatic logic [IDX_W-1:0] alt_of(input logic [IDX_W-1:0] home,
                                                input logic [LVL_W-1:0] lvl);
        logic [IDX_W-1:0] m;
        m = '0;
        for (int b = 0; b < IDX_W; b++) begin
            if (b == IDX_W - 1 - int'(lvl)) m[b] = 1'b1;
        end
        return home ^ m;
    endfunction

    assign accept    = (st_q == ST_IDLE) && req_valid && req_miss;
    assign rsp_take  = (st_q == ST_PROBE) && rsp_valid;
    assign rd_idx    = (st_q == ST_IDLE) ? req_idx : ctx_q.home;
    assign pick_from = (st_q == ST_IDLE) ? '0 : ({1'b0, ctx_q.lvl} + (LVL_W+1)'(1));

    assign up_we  = rsp_take && rsp_hit;
    assign up_lvl = ctx_q.lvl;
    assign up_idx = ctx_q.home;
    assign up_way = rsp_way;
    assign up_val = rsp_victim_misplaced;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ctx_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        ctx_q.home <= req_idx;
                        if (pick_found) begin
                            st_q      <= ST_PROBE;
                            ctx_q.lvl <= pick_lvl;
                            ctx_q.en  <= maps[pick_lvl];
                        end else begin
                            st_q <= ST_FWD;
                        end
                    end
                end
                ST_PROBE: begin
                    if (rsp_take) begin
                        if (rsp_hit) begin
                            st_q      <= ST_SWAP;
                            ctx_q.way <= rsp_way;
                        end else if (pick_found) begin
                            ctx_q.lvl <= pick_lvl;
                            ctx_q.en  <= maps[pick_lvl];
                        end else begin
                            st_q <= ST_FWD;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (st_q == ST_IDLE);
    assign probe_valid   = (st_q == ST_PROBE);
    assign probe_idx     = alt_of(ctx_q.home, ctx_q.lvl);
    assign probe_way_en  = ctx_q.en;
    assign probe_cnt     = CNT_W'(ones_of(64'(ctx_q.en)));
    assign probe_level   = ctx_q.lvl;
    assign swap_valid    = (st_q == ST_SWAP);
    assign swap_home_idx = ctx_q.home;
    assign swap_alt_idx  = alt_of(ctx_q.home, ctx_q.lvl);
    assign swap_way      = ctx_q.way;
    assign swap_level    = ctx_q.lvl;
    assign fwd_valid     = (st_q == ST_FWD);
    assign fwd_idx       = ctx_q.home;

endmodule

// File: rtl/mlr_reaccess.sv
module mlr_reaccess #(
    parameter int IDX_W  = 4,
    parameter int WAYS   = 4,
    parameter int LEVELS = 2,
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    parameter int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    parameter int CNT_W  = $clog2(WAYS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_miss,
    input  logic [IDX_W-1:0] req_idx,
    output logic             req_ready,
    input  logic             mark_valid,
    input  logic [LVL_W-1:0] mark_level,
    input  logic [IDX_W-1:0] mark_idx,
    input  logic [WAY_W-1:0] mark_way,
    input  logic             mark_set,
    output logic             probe_valid,
    output logic [IDX_W-1:0] probe_idx,
    output logic [WAYS-1:0]  probe_way_en,
    output logic [CNT_W-1:0] probe_cnt,
    output logic [LVL_W-1:0] probe_level,
    input  logic             rsp_valid,
    input  logic             rsp_hit,
    input  logic [WAY_W-1:0] rsp_way,
    input  logic             rsp_victim_misplaced,
    output logic             swap_valid,
    output logic [IDX_W-1:0] swap_home_idx,
    output logic [IDX_W-1:0] swap_alt_idx,
    output logic [WAY_W-1:0] swap_way,
    output logic [LVL_W-1:0] swap_level,
    output logic             fwd_valid,
    output logic [IDX_W-1:0] fwd_idx
);
    logic [LEVELS-1:0][WAYS-1:0] maps;
    logic [IDX_W-1:0]            rd_idx;
    logic [LVL_W:0]              pick_from;
    logic                        pick_found;
    logic [LVL_W-1:0]            pick_lvl;
    logic                        up_we;
    logic [LVL_W-1:0]            up_lvl;
    logic [IDX_W-1:0]            up_idx;
    logic [WAY_W-1:0]            up_way;
    logic                        up_val;

    mlr_map_store #(
        .IDX_W(IDX_W), .WAYS(WAYS), .LEVELS(LEVELS), .LVL_W(LVL_W), .WAY_W(WAY_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .mk_we(mark_valid), .mk_lvl(mark_level), .mk_idx(mark_idx),
        .mk_way(mark_way), .mk_val(mark_set),
        .up_we(up_we), .up_lvl(up_lvl), .up_idx(up_idx),
        .up_way(up_way), .up_val(up_val),
        .rd_idx(rd_idx), .rd_maps(maps)
    );

    mlr_level_pick #(
        .WAYS(WAYS), .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) u_pick (
        .maps(maps), .from_lvl(pick_from), .found(pick_found), .lvl(pick_lvl)
    );

    mlr_seq #(
        .IDX_W(IDX_W), .WAYS(WAYS), .LEVELS(LEVELS),
        .LVL_W(LVL_W), .WAY_W(WAY_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_miss(req_miss), .req_idx(req_idx),
        .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_victim_misplaced(rsp_victim_misplaced),
        .maps(maps), .pick_found(pick_found), .pick_lvl(pick_lvl),
        .rd_idx(rd_idx), .pick_from(pick_from),
        .up_we(up_we), .up_lvl(up_lvl), .up_idx(up_idx),
        .up_way(up_way), .up_val(up_val),
        .probe_valid(probe_valid), .probe_idx(probe_idx),
        .probe_way_en(probe_way_en), .probe_cnt(probe_cnt),
        .probe_level(probe_level),
        .swap_valid(swap_valid), .swap_home_idx(swap_home_idx),
        .swap_alt_idx(swap_alt_idx), .swap_way(swap_way),
        .swap_level(swap_level),
        .fwd_valid(fwd_valid), .fwd_idx(fwd_idx)
    );

endmodule

// File: rtl/mlr_reaccess_chk.sv
module mlr_reaccess_chk #(
    parameter int IDX_W = 4,
    parameter int WAYS  = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             probe_valid,
    input logic [IDX_W-1:0] probe_idx,
    input logic [WAYS-1:0]  probe_way_en,
    input logic [CNT_W-1:0] probe_cnt,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             swap_valid,
    input logic             fwd_valid
);
    // R1
    out_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({probe_valid, swap_valid, fwd_valid}));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !probe_valid && !swap_valid && !fwd_valid);

    // R4
    probe_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        probe_valid |-> probe_way_en != '0);

    // R5
    probe_count_chk: assert property (@(posedge clk) disable iff (rst)
        probe_valid |-> int'(probe_cnt) == $countones(probe_way_en));

    // R9
    probe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        probe_valid && !rsp_valid |=> probe_valid && $stable(probe_way_en) && $stable(probe_idx));

    // R8
    swap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        swap_valid |-> $past(probe_valid && rsp_valid && rsp_hit));

    // R7
    fwd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |=> !fwd_valid);

endmodule

bind mlr_reaccess mlr_reaccess_chk #(
    .IDX_W(IDX_W), .WAYS(WAYS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready),
    .probe_valid(probe_valid), .probe_idx(probe_idx),
    .probe_way_en(probe_way_en), .probe_cnt(probe_cnt),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .swap_valid(swap_valid), .fwd_valid(fwd_valid)
);

// File: tb/mlr_reaccess_tb.sv
`timescale 1ns/1ps
module mlr_reaccess_tb;
    localparam int IDX_W  = 4;
    localparam int WAYS   = 4;
    localparam int LEVELS = 2;
    localparam int LVL_W  = 1;
    localparam int WAY_W  = 2;
    localparam int CNT_W  = 3;
    localparam int SETS   = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_miss = 0;
    logic [IDX_W-1:0] req_idx = '0;
    logic req_ready;
    logic mark_valid = 0;
    logic [LVL_W-1:0] mark_level = '0;
    logic [IDX_W-1:0] mark_idx = '0;
    logic [WAY_W-1:0] mark_way = '0;
    logic mark_set = 0;
    logic probe_valid;
    logic [IDX_W-1:0] probe_idx;
    logic [WAYS-1:0] probe_way_en;
    logic [CNT_W-1:0] probe_cnt;
    logic [LVL_W-1:0] probe_level;
    logic rsp_valid = 0, rsp_hit = 0, rsp_vm = 0;
    logic [WAY_W-1:0] rsp_way = '0;
    logic swap_valid;
    logic [IDX_W-1:0] swap_home_idx, swap_alt_idx;
    logic [WAY_W-1:0] swap_way;
    logic [LVL_W-1:0] swap_level;
    logic fwd_valid;
    logic [IDX_W-1:0] fwd_idx;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [WAYS-1:0] mdl [LEVELS][SETS];

    always #2 clk = ~clk;

    mlr_reaccess #(.IDX_W(IDX_W), .WAYS(WAYS), .LEVELS(LEVELS)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_miss(req_miss), .req_idx(req_idx),
        .req_ready(req_ready),
        .mark_valid(mark_valid), .mark_level(mark_level), .mark_idx(mark_idx),
        .mark_way(mark_way), .mark_set(mark_set),
        .probe_valid(probe_valid), .probe_idx(probe_idx),
        .probe_way_en(probe_way_en), .probe_cnt(probe_cnt),
        .probe_level(probe_level),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_victim_misplaced(rsp_vm),
        .swap_valid(swap_valid), .swap_home_idx(swap_home_idx),
        .swap_alt_idx(swap_alt_idx), .swap_way(swap_way),
        .swap_level(swap_level),
        .fwd_valid(fwd_valid), .fwd_idx(fwd_idx)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int ones(input logic [WAYS-1:0] v);
        int n = 0;
        for (int b = 0; b < WAYS; b++) n += int'(v[b]);
        return n;
    endfunction

    function automatic int alt_idx(input int home, input int lvl);
        return home ^ ((1 << (IDX_W - 1)) >> lvl);
    endfunction

    task automatic do_mark(input int l, input int i, input int w, input bit v);
        @(negedge clk);
        mark_valid = 1; mark_level = l[LVL_W-1:0]; mark_idx = i[IDX_W-1:0];
        mark_way = w[WAY_W-1:0]; mark_set = v;
        @(negedge clk);
        mark_valid = 0;
        mdl[l][i][w] = v;
    endtask

    // One miss transaction. hit_lvl < 0 means every probe misses.
    task automatic access(input int idx, input int hit_lvl, input int hit_way,
                          input bit vm, input bit stall, input bit clash);
        int cur;
        int lf;
        bit fin;
        @(negedge clk);
        req_valid = 1; req_miss = 1; req_idx = idx[IDX_W-1:0];
        @(negedge clk);
        req_valid = 0; req_miss = 0;
        cur = 0;
        fin = 0;
        while (!fin) begin
            lf = -1;
            for (int l = LEVELS - 1; l >= cur; l--) if (mdl[l][idx] != '0) lf = l;
            if (lf < 0) begin
                chk(fwd_valid == 1'b1, "R7 forward raised", fwd_valid, 1);
                chk(int'(fwd_idx) == idx, "R7 forward index", fwd_idx, idx);
                chk(probe_valid == 1'b0, "R7 no probe", probe_valid, 0);
                @(negedge clk);
                chk(fwd_valid == 1'b0 && req_ready == 1'b1, "R7 single pulse", fwd_valid, 0);
                fin = 1;
            end else begin
                chk(probe_valid == 1'b1, "R4 probe raised", probe_valid, 1);
                chk(int'(probe_idx) == alt_idx(idx, lf), "R4 alternate index", probe_idx, alt_idx(idx, lf));
                chk(probe_way_en == mdl[lf][idx], "R4 way enables", probe_way_en, mdl[lf][idx]);
                chk(int'(probe_cnt) == ones(mdl[lf][idx]), "R5 probe count", probe_cnt, ones(mdl[lf][idx]));
                chk(int'(probe_level) == lf, "R6 level order", probe_level, lf);
                if (stall) begin
                    req_valid = 1; req_miss = 1; req_idx = idx[IDX_W-1:0] ^ 4'h1;
                    @(negedge clk);
                    chk(probe_valid && probe_way_en == mdl[lf][idx] && !req_ready,
                        "R9 probe held busy", probe_way_en, mdl[lf][idx]);
                end
                rsp_valid = 1; rsp_hit = (lf == hit_lvl); rsp_way = hit_way[WAY_W-1:0]; rsp_vm = vm;
                if (clash && lf == hit_lvl) begin
                    mark_valid = 1; mark_level = lf[LVL_W-1:0]; mark_idx = idx[IDX_W-1:0];
                    mark_way = hit_way[WAY_W-1:0]; mark_set = ~vm;
                end
                @(negedge clk);
                rsp_valid = 0; rsp_hit = 0; mark_valid = 0; req_valid = 0; req_miss = 0;
                if (lf == hit_lvl) begin
                    chk(swap_valid == 1'b1, "R8 swap raised", swap_valid, 1);
                    chk(int'(swap_home_idx) == idx, "R8 swap home", swap_home_idx, idx);
                    chk(int'(swap_alt_idx) == alt_idx(idx, lf), "R8 swap alternate", swap_alt_idx, alt_idx(idx, lf));
                    chk(int'(swap_way) == hit_way && int'(swap_level) == lf, "R8 swap way", swap_way, hit_way);
                    mdl[lf][idx][hit_way] = vm;
                    @(negedge clk);
                    chk(req_ready && !swap_valid && !probe_valid, "R9 back to idle", req_ready, 1);
                    fin = 1;
                end else begin
                    cur = lf + 1;
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        for (int l = 0; l < LEVELS; l++)
            for (int s = 0; s < SETS; s++) mdl[l][s] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(!probe_valid && !swap_valid && !fwd_valid, "R1 outputs idle", probe_valid, 0);
        access(5, -1, 0, 0, 0, 0);   // R1 empty maps forward directly

        // R3 normal hit ignored
        @(negedge clk); req_valid = 1; req_miss = 0; req_idx = 4'd3;
        @(negedge clk); req_valid = 0;
        chk(req_ready && !probe_valid && !fwd_valid, "R3 hit ignored", probe_valid, 0);
        @(negedge clk);
        chk(req_ready && !probe_valid && !fwd_valid, "R3 still idle", fwd_valid, 0);

        // R2 mark then level-0 probe misses, forward
        do_mark(0, 0, 1, 1);
        access(0, -1, 0, 0, 0, 0);
        // R6 two levels, hit on level 1 way 3, correctly placed victim clears
        do_mark(1, 0, 0, 1);
        do_mark(1, 0, 3, 1);
        access(0, 1, 3, 0, 1, 0);
        // R8 victim itself misplaced keeps bit
        access(0, 1, 0, 1, 0, 0);
        access(0, -1, 0, 0, 0, 0);
        // R2 clear flags
        do_mark(0, 0, 1, 0);
        do_mark(1, 0, 0, 0);
        access(0, -1, 0, 0, 0, 0);
        // R6 skip empty level 0
        do_mark(1, 9, 2, 1);
        access(9, -1, 0, 0, 1, 0);
        // R10 same-bit mark loses to swap update
        access(9, 1, 2, 0, 0, 1);
        access(9, -1, 0, 0, 0, 0);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int nm = $urandom_range(0, 3);
            int idx, hl, hw;
            for (int k = 0; k < nm; k++)
                do_mark($urandom_range(0, LEVELS - 1), $urandom_range(0, SETS - 1),
                        $urandom_range(0, WAYS - 1), ($urandom_range(0, 3) != 0));
            idx = $urandom_range(0, SETS - 1);
            hl = $urandom_range(0, LEVELS) - 1;
            hw = 0;
            if (hl >= 0 && mdl[hl][idx] != '0) begin
                do hw = $urandom_range(0, WAYS - 1); while (!mdl[hl][idx][hw]);
            end else begin
                hl = -1;
            end
            access(idx, hl, hw, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                   $urandom_range(0, 3) == 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule